// File: doc/BRIEF.md
# Data Memory and Peripheral Access Unit

This unit carries out the loads and stores of a 16-bit core whose program and data live in separate memories. Each request from the execute stage names an access kind, a 16-bit byte address, the store data and the current value of the destination register. The unit routes the access to one of three places: a read/write data RAM at the bottom of the address space, a read-only data area placed directly above the RAM, or one of two memory-mapped registers of a serial port near the top of the address space. It returns the load result, a stall signal for the core and an invalid-access fault. The core turns that fault into its exception number 2.

The RAM and the read-only area together form one byte space. That space is held in two external 8-bit banks, one for even and one for odd byte addresses. Each bank has one cycle of read latency. Because the banks are split, a 16-bit access at an odd address completes in the same number of cycles as an aligned one. Word values are stored big-endian. Byte loads either merge into the old register value or sign-extend. The serial port registers answer through a strobe/ready handshake and can only be reached with aligned word accesses.

Top module: `mem_io_unit`

## Requirements
- R1: While reset is held and after it is released with no request, busy, fault, ld_valid, p_rd, p_wr, ev_en and od_en are all 0.
- R2: Word store (op 4) writes wdata[15:8] to byte a and wdata[7:0] to byte a+1. It completes in the request cycle with busy 0. Word load (op 0) returns {byte a, byte a+1}. It holds busy at 1 in the request cycle and shows the result with ld_valid 1 in the following cycle.
- R3: Word loads and stores at an odd address use the same byte order and the same cycle count as aligned ones.
- R4: Load-low (op 1) returns {old[15:8], byte a}. Load-high (op 2) returns {byte a, old[7:0]}.
- R5: Load-byte (op 3) returns byte a sign-extended to 16 bits.
- R6: Store-low (op 5) writes wdata[7:0] to byte a, and store-high (op 6) writes wdata[15:8] to byte a. Neighbouring bytes keep their values.
- R7: Bytes RAM_BYTES to RAM_BYTES+ROM_BYTES-1 can be read with every load kind. This includes a word load whose first byte is the last RAM byte.
- R8: A store that touches any byte at or above RAM_BYTES raises fault in the request cycle. No byte is written.
- R9: Any of the following raises fault in the request cycle with busy 0 and no bank write and no strobe: a load whose last byte lies outside the data space and is not a serial register; a store to such an address; op 7.
- R10: A word load at 0xFFF8 (status/control, p_sel bit 0) or at 0xFFFA (data, p_sel bit 1) pulses p_rd for one cycle. Busy stays at 1 until p_ready is seen. In the p_ready cycle, busy is 0, ld_valid is 1 and ld_data equals p_rdata.
- R11: A word store to a serial register pulses p_wr for one cycle with p_wdata = wdata. Busy stays at 1 until p_ready is seen, and ld_valid stays 0 throughout.
- R12: A byte access or an odd address aimed at the serial register window raises fault, and neither strobe is raised.
- R13: A request that arrives while the unit waits for p_ready has no effect: it causes no strobe, no bank write and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access request, one cycle per access |
| op | input | 3 | Access kind (0..6, 7 reserved) |
| addr | input | 16 | Byte address |
| wdata | input | 16 | Store data |
| old_val | input | 16 | Current destination register value |
| busy | output | 1 | Stall the core |
| fault | output | 1 | Invalid access |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 16 | Load result |
| ev_en | output | 1 | Even bank enable |
| ev_we | output | 1 | Even bank write enable |
| ev_idx | output | BIDX_W | Even bank index |
| ev_wdata | output | 8 | Even bank write byte |
| ev_rdata | input | 8 | Even bank read byte, one cycle after enable |
| od_en | output | 1 | Odd bank enable |
| od_we | output | 1 | Odd bank write enable |
| od_idx | output | BIDX_W | Odd bank index |
| od_wdata | output | 8 | Odd bank write byte |
| od_rdata | input | 8 | Odd bank read byte, one cycle after enable |
| p_rd | output | 1 | Peripheral read strobe |
| p_wr | output | 1 | Peripheral write strobe |
| p_sel | output | 2 | Register select, one-hot with a strobe |
| p_wdata | output | 16 | Peripheral write data |
| p_rdata | input | 16 | Peripheral read data |
| p_ready | input | 1 | Peripheral transfer complete |

## Verification
The checker watches four properties on every cycle. Neither bank is ever written at an index that falls in the read-only area. A fault never appears together with a bank write, a strobe or busy. Strobes last one cycle and always carry a one-hot select, and each read strobe is followed by either a stall or a result. A load result never appears unless the unit stalled in the cycle before. The directed scenarios cover what the checker cannot see: byte order across the two banks, merging with the old value, sign extension, the RAM-to-read-only boundary, the wait length on the peripheral side, and whether a request made during a wait was really dropped.

// File: rtl/mem_io_unit.sv
`timescale 1ns/1ps
module mem_io_unit #(
  parameter int RAM_BYTES = 8192,
  parameter int ROM_BYTES = 256,
  parameter logic [15:0] UART_CTL_ADDR = 16'hFFF8,
  parameter logic [15:0] UART_DAT_ADDR = 16'hFFFA,
  localparam int DATA_BYTES = RAM_BYTES + ROM_BYTES,
  localparam int BANK_DEPTH = DATA_BYTES / 2,
  localparam int BIDX_W = $clog2(BANK_DEPTH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [2:0]        op,
  input  logic [15:0]       addr,
  input  logic [15:0]       wdata,
  input  logic [15:0]       old_val,
  output logic              busy,
  output logic              fault,
  output logic              ld_valid,
  output logic [15:0]       ld_data,
  output logic              ev_en,
  output logic              ev_we,
  output logic [BIDX_W-1:0] ev_idx,
  output logic [7:0]        ev_wdata,
  input  logic [7:0]        ev_rdata,
  output logic              od_en,
  output logic              od_we,
  output logic [BIDX_W-1:0] od_idx,
  output logic [7:0]        od_wdata,
  input  logic [7:0]        od_rdata,
  output logic              p_rd,
  output logic              p_wr,
  output logic [1:0]        p_sel,
  output logic [15:0]       p_wdata,
  input  logic [15:0]       p_rdata,
  input  logic              p_ready
);

  localparam logic [2:0] OP_LDW = 3'd0, OP_LDL = 3'd1, OP_LDH = 3'd2, OP_LDB = 3'd3;
  localparam logic [2:0] OP_STW = 3'd4, OP_STL = 3'd5, OP_STH = 3'd6, OP_BAD = 3'd7;
  localparam logic [16:0] RAM_END  = 17'(RAM_BYTES);
  localparam logic [16:0] DATA_END = 17'(DATA_BYTES);

  typedef enum logic [1:0] {S_IDLE, S_MEMRD, S_PWAIT} st_t;
  st_t state;

  logic [2:0]  op_q;
  logic [15:0] old_q;
  logic        odd_q;

  wire accept  = req && (state != S_PWAIT);
  wire is_word = (op == OP_LDW) || (op == OP_STW);
  wire is_st   = (op == OP_STW) || (op == OP_STL) || (op == OP_STH);
  wire is_ld   = !op[2];
  wire odd     = addr[0];

  wire [16:0] last_b  = {1'b0, addr} + {16'b0, is_word};
  wire in_data   = last_b < DATA_END;
  wire hits_rom  = is_st && (last_b >= RAM_END);
  wire mem_ok    = in_data && !hits_rom && (op != OP_BAD);

  wire sel_ctl   = addr == UART_CTL_ADDR;
  wire sel_dat   = addr == UART_DAT_ADDR;
  wire per_ok    = (sel_ctl || sel_dat) && (op == OP_LDW || op == OP_STW);
  wire bad       = !(mem_ok || per_ok);

  wire go_mem    = accept && mem_ok;
  wire go_per    = accept && per_ok;

  wire [BIDX_W-1:0] idx_lo = addr[BIDX_W:1];
  wire [BIDX_W-1:0] idx_nx = idx_lo + {{(BIDX_W-1){1'b0}}, 1'b1};
  wire [7:0] byte_src = (op == OP_STH) ? wdata[15:8] : wdata[7:0];

  assign ev_en    = go_mem && (is_word || !odd);
  assign od_en    = go_mem && (is_word || odd);
  assign ev_we    = ev_en && is_st;
  assign od_we    = od_en && is_st;
  assign ev_idx   = (is_word && odd) ? idx_nx : idx_lo;
  assign od_idx   = idx_lo;
  assign ev_wdata = (op == OP_STW) ? (odd ? wdata[7:0] : wdata[15:8]) : byte_src;
  assign od_wdata = (op == OP_STW) ? (odd ? wdata[15:8] : wdata[7:0]) : byte_src;

  assign p_rd    = go_per && (op == OP_LDW);
  assign p_wr    = go_per && (op == OP_STW);
  assign p_sel   = {sel_dat, sel_ctl} & {2{go_per}};
  assign p_wdata = wdata;

  assign fault = accept && bad;
  assign busy  = ((state == S_PWAIT) && !p_ready) || (accept && !bad && (is_ld || per_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      op_q  <= OP_LDW;
      old_q <= '0;
      odd_q <= 1'b0;
    end else if (state == S_PWAIT) begin
      if (p_ready) state <= S_IDLE;
    end else if (go_per) begin
      state <= S_PWAIT;
      op_q  <= op;
    end else if (go_mem && is_ld) begin
      state <= S_MEMRD;
      op_q  <= op;
      old_q <= old_val;
      odd_q <= odd;
    end else begin
      state <= S_IDLE;
    end
  end

  wire [7:0] hi_b = odd_q ? od_rdata : ev_rdata;
  wire [7:0] lo_b = odd_q ? ev_rdata : od_rdata;

  assign ld_valid = (state == S_MEMRD) || ((state == S_PWAIT) && p_ready && (op_q == OP_LDW));

  always_comb begin
    ld_data = '0;
    if (state == S_MEMRD) begin
      case (op_q)
        OP_LDW:  ld_data = {hi_b, lo_b};
        OP_LDL:  ld_data = {old_q[15:8], hi_b};
        OP_LDH:  ld_data = {hi_b, old_q[7:0]};
        default: ld_data = {{8{hi_b[7]}}, hi_b};
      endcase
    end else if (state == S_PWAIT) begin
      ld_data = p_rdata;
    end
  end

endmodule

// File: rtl/mem_io_unit_chk.sv
`timescale 1ns/1ps
module mem_io_unit_chk #(
  parameter int RAM_BYTES = 8192,
  parameter int BIDX_W = 13
)(
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              fault,
  input logic              ld_valid,
  input logic              ev_we,
  input logic              od_we,
  input logic [BIDX_W-1:0] ev_idx,
  input logic [BIDX_W-1:0] od_idx,
  input logic              p_rd,
  input logic              p_wr,
  input logic [1:0]        p_sel
);

  a_r8_rom_never_written_even: assert property (@(posedge clk) disable iff (!rst_n)
    ev_we |-> (32'({ev_idx, 1'b0}) < RAM_BYTES));

  a_r8_rom_never_written_odd: assert property (@(posedge clk) disable iff (!rst_n)
    od_we |-> (32'({od_idx, 1'b1}) < RAM_BYTES));

  a_r9_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !(ev_we || od_we || p_rd || p_wr || busy));

  a_r10_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rd || p_wr) |-> $onehot(p_sel));

  a_r10_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    (p_rd || p_wr) |=> !(p_rd || p_wr));

  a_r10_read_stalls_or_returns: assert property (@(posedge clk) disable iff (!rst_n)
    p_rd |=> (busy || ld_valid));

  a_r2_valid_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ld_valid |-> $past(busy));

endmodule

bind mem_io_unit mem_io_unit_chk #(.RAM_BYTES(RAM_BYTES), .BIDX_W(BIDX_W)) u_chk (.*);

// File: tb/mem_io_unit_tb.sv
`timescale 1ns/1ps
module mem_io_unit_tb_top;
  localparam int RAM_BYTES = 8192;
  localparam int ROM_BYTES = 256;
  localparam int DEPTH = (RAM_BYTES + ROM_BYTES) / 2;
  localparam int IW = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic req = 0;
  logic [2:0] op = 0;
  logic [15:0] addr = 0, wdata = 0, old_val = 0;
  logic busy, fault, ld_valid;
  logic [15:0] ld_data;
  logic ev_en, ev_we, od_en, od_we;
  logic [IW-1:0] ev_idx, od_idx;
  logic [7:0] ev_wdata, od_wdata;
  logic [7:0] ev_rdata = 0, od_rdata = 0;
  logic p_rd, p_wr;
  logic [1:0] p_sel;
  logic [15:0] p_wdata;
  logic [15:0] p_rdata = 0;
  logic p_ready = 0;

  logic [7:0] ev_mem [DEPTH];
  logic [7:0] od_mem [DEPTH];

  int nvec = 0, nerr = 0;

  always #2.5 clk = ~clk;

  mem_io_unit #(.RAM_BYTES(RAM_BYTES), .ROM_BYTES(ROM_BYTES)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .op(op), .addr(addr), .wdata(wdata),
    .old_val(old_val), .busy(busy), .fault(fault), .ld_valid(ld_valid),
    .ld_data(ld_data), .ev_en(ev_en), .ev_we(ev_we), .ev_idx(ev_idx),
    .ev_wdata(ev_wdata), .ev_rdata(ev_rdata), .od_en(od_en), .od_we(od_we),
    .od_idx(od_idx), .od_wdata(od_wdata), .od_rdata(od_rdata), .p_rd(p_rd),
    .p_wr(p_wr), .p_sel(p_sel), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .p_ready(p_ready));

  always @(posedge clk) begin
    if (ev_en) begin
      ev_rdata <= ev_mem[ev_idx];
      if (ev_we) ev_mem[ev_idx] <= ev_wdata;
    end
    if (od_en) begin
      od_rdata <= od_mem[od_idx];
      if (od_we) od_mem[od_idx] <= od_wdata;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  task automatic drive(logic [2:0] o, logic [15:0] a, logic [15:0] d, logic [15:0] old);
    @(negedge clk);
    req = 1; op = o; addr = a; wdata = d; old_val = old;
  endtask

  task automatic do_store(logic [2:0] o, logic [15:0] a, logic [15:0] d, string tag);
    drive(o, a, d, 16'h0);
    #1;
    chk({tag, " store busy"}, busy, 0);
    chk({tag, " store fault"}, fault, 0);
    @(negedge clk); req = 0;
  endtask

  task automatic do_load(logic [2:0] o, logic [15:0] a, logic [15:0] old, logic [15:0] exp, string tag);
    drive(o, a, 16'h0, old);
    #1;
    chk({tag, " load busy"}, busy, 1);
    chk({tag, " load fault"}, fault, 0);
    @(negedge clk); req = 0;
    #1;
    chk({tag, " ld_valid"}, ld_valid, 1);
    chk({tag, " ld_data"}, ld_data, exp);
  endtask

  task automatic do_fault(logic [2:0] o, logic [15:0] a, string tag);
    drive(o, a, 16'hBEEF, 16'h0);
    #1;
    chk({tag, " fault"}, fault, 1);
    chk({tag, " quiet"}, {busy, ev_we, od_we, p_rd, p_wr}, 5'b0);
    @(negedge clk); req = 0;
    #1;
    chk({tag, " no result"}, {ld_valid, busy}, 2'b0);
  endtask

  task automatic do_periph(logic [2:0] o, logic [15:0] a, logic [15:0] d, int waits,
                           logic [15:0] rd, logic [1:0] sel, string tag);
    logic is_rd;
    is_rd = (o == 3'd0);
    drive(o, a, d, 16'h0);
    #1;
    chk({tag, " strobes"}, {p_rd, p_wr}, {is_rd, !is_rd});
    chk({tag, " sel"}, p_sel, sel);
    chk({tag, " busy"}, busy, 1);
    if (!is_rd) chk({tag, " p_wdata"}, p_wdata, d);
    @(negedge clk); req = 0;
    for (int i = 0; i < waits; i++) begin
      #1;
      chk({tag, " wait busy"}, {busy, p_rd, p_wr, ld_valid}, 4'b1000);
      @(negedge clk);
    end
    p_ready = 1; p_rdata = rd;
    #1;
    chk({tag, " done busy"}, busy, 0);
    chk({tag, " done valid"}, ld_valid, is_rd);
    if (is_rd) chk({tag, " done data"}, ld_data, rd);
    @(negedge clk); p_ready = 0;
    #1;
    chk({tag, " after"}, {busy, ld_valid}, 2'b0);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 during reset", {busy, fault, ld_valid, p_rd, p_wr, ev_en, od_en}, 7'b0);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    #1;
    chk("R1 after reset", {busy, fault, ld_valid, p_rd, p_wr, ev_en, od_en}, 7'b0);
  endtask

  task automatic t_aligned();
    do_store(3'd4, 16'h0100, 16'hA1B2, "R2");
    do_load(3'd0, 16'h0100, 16'h0000, 16'hA1B2, "R2 aligned word");
    do_load(3'd1, 16'h0100, 16'h1234, 16'h12A1, "R4 low merge");
    do_load(3'd2, 16'h0101, 16'h1234, 16'hB234, "R4 high merge");
    do_load(3'd3, 16'h0100, 16'h0000, 16'hFFA1, "R5 neg byte");
    do_store(3'd4, 16'h0200, 16'h3C7F, "R5");
    do_load(3'd3, 16'h0201, 16'hFFFF, 16'h007F, "R5 pos byte");
  endtask

  task automatic t_unaligned();
    do_store(3'd4, 16'h0301, 16'hCAFE, "R3");
    do_load(3'd0, 16'h0301, 16'h0, 16'hCAFE, "R3 odd word");
    do_load(3'd0, 16'h0300, 16'h0, 16'h00CA, "R3 even before");
    do_load(3'd0, 16'h0302, 16'h0, 16'hFE00, "R3 even after");
  endtask

  task automatic t_bytestore();
    do_store(3'd4, 16'h0400, 16'h1111, "R6");
    do_store(3'd5, 16'h0400, 16'hAB77, "R6");
    do_store(3'd6, 16'h0401, 16'h99CC, "R6");
    do_load(3'd0, 16'h0400, 16'h0, 16'h7799, "R6 bytes");
    do_load(3'd0, 16'h0401, 16'h0, 16'h9900, "R6 neighbour");
  endtask

  task automatic t_rom();
    do_load(3'd0, 16'h2000, 16'h0, 16'h5A5B, "R7 rom word");
    do_store(3'd5, 16'h1FFF, 16'h00EE, "R7");
    do_load(3'd0, 16'h1FFF, 16'h0, 16'hEE5A, "R7 boundary word");
    do_load(3'd3, 16'h20FF, 16'h0, 16'hFFA5, "R7 last rom byte");
  endtask

  task automatic t_faults();
    do_fault(3'd4, 16'h2000, "R8 word into rom");
    do_fault(3'd5, 16'h2010, "R8 byte into rom");
    do_fault(3'd4, 16'h1FFF, "R8 word crossing");
    do_load(3'd0, 16'h2000, 16'h0, 16'h5A5B, "R8 rom unchanged");
    do_load(3'd0, 16'h1FFF, 16'h0, 16'hEE5A, "R8 ram unchanged");
    do_fault(3'd0, 16'h20FF, "R9 word past end");
    do_fault(3'd3, 16'h2100, "R9 unmapped byte");
    do_fault(3'd0, 16'h8000, "R9 unmapped word");
    do_fault(3'd4, 16'hFFFC, "R9 empty slot");
    do_fault(3'd7, 16'h0100, "R9 reserved op");
  endtask

  task automatic t_periph();
    do_periph(3'd0, 16'hFFF8, 16'h0, 3, 16'h000C, 2'b01, "R10 status read");
    do_periph(3'd0, 16'hFFFA, 16'h0, 0, 16'h0041, 2'b10, "R10 data read");
    do_periph(3'd4, 16'hFFFA, 16'h0055, 2, 16'hFFFF, 2'b10, "R11 data write");
    do_fault(3'd3, 16'hFFFA, "R12 byte load");
    do_fault(3'd5, 16'hFFF8, "R12 byte store");
    do_fault(3'd0, 16'hFFF9, "R12 odd word");
    do_fault(3'd2, 16'hFFFA, "R12 high load");
  endtask

  task automatic t_ignore();
    drive(3'd4, 16'hFFF8, 16'h0008, 16'h0);
    #1;
    chk("R13 first strobe", p_wr, 1);
    @(negedge clk);
    req = 1; op = 3'd4; addr = 16'h0500; wdata = 16'hDEAD;
    #1;
    chk("R13 ignored", {ev_we, od_we, p_rd, p_wr, fault, busy}, 6'b000001);
    @(negedge clk); req = 0; p_ready = 1;
    #1;
    chk("R13 release", busy, 0);
    @(negedge clk); p_ready = 0;
    do_load(3'd0, 16'h0500, 16'h0, 16'h0000, "R13 ram untouched");
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      ev_mem[i] = 8'h00;
      od_mem[i] = 8'h00;
    end
    for (int a = RAM_BYTES; a < RAM_BYTES + ROM_BYTES; a++) begin
      if (a % 2 == 0) ev_mem[a / 2] = 8'(a) ^ 8'h5A;
      else            od_mem[a / 2] = 8'(a) ^ 8'h5A;
    end
    t_reset();
    t_aligned();
    t_unaligned();
    t_bytestore();
    t_rom();
    t_faults();
    t_periph();
    t_ignore();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end
endmodule